// File: doc/BRIEF.md
# External Interrupt Router

This block collects level-sensitive interrupt requests from a small, parameterised set of sources and delivers them to interrupt targets. Each hardware thread owns two targets, one for machine mode and one for supervisor mode. Software programs a priority for every source and, for every target, a set of enabled sources and a priority threshold. A target's interrupt line is raised when an enabled source is pending and its priority is strictly above that target's threshold.

Software takes ownership of an interrupt by reading the target's claim register. The read returns the identifier of the best eligible source and clears its pending bit. Software hands the interrupt back by writing the same identifier to the same register. Identifier 0 means "no interrupt". A source has at most one owner at any time. A target holds at most one claim. A thread whose target holds a claim receives no further interrupt posts until that claim is completed.

Registers are reached over a single-beat request/response bus with valid/ready handshakes. A request is accepted when `req_valid_i` and `req_ready_o` are both high. Every accepted request produces exactly one response one cycle later. `req_ready_o` is low only while a response is waiting and `rsp_ready_i` is low, so a stalled response blocks new requests. All side effects, including claims, take place at acceptance.

Top module: `extirq_router`

## Requirements
- R1: After a synchronous active-high reset, all interrupt lines are low, no response is pending, `req_ready_o` is high, and every register reads 0.
- R2: Source `s` (1..NUM_SRC) has a priority register at byte address 4*s. Only the low PRIO_W bits are stored, and the upper bits read as 0. Address 0 and unused source slots read 0 and ignore writes.
- R3: A change on a source input reaches the interrupt lines after exactly three rising clock edges. Two edges after the change the line still shows the old value.
- R4: A target's line is high only for an enabled pending source whose priority is strictly greater than the target's threshold. Threshold changes take effect on the line one edge after the write is accepted.
- R5: A claim read returns the eligible source of highest priority, choosing the lower identifier on a tie, and clears its pending bit. It returns 0 when no source is eligible.
- R6: A source claimed by one target cannot be returned by a claim on any other target until it is completed.
- R7: While a target holds a claim, further claim reads on that target return 0 and change no state.
- R8: A completion write whose identifier differs from the target's outstanding claim is ignored.
- R9: A claimed source does not become pending again before its completion. After the completion, a source input that is still high makes the source pending again.
- R10: While either target of a hardware thread holds a claim, both interrupt lines of that thread stay low. Other threads are unaffected.
- R11: `req_ready_o` is low while a response waits with `rsp_ready_i` low. The response data stays stable until it is taken.
- R12: Register layout:
  - The pending word at 0x080 holds source `s` in bit `s`, with bit 0 reading 0.
  - Target `c` has its registers at 0x100 + 16*c: enable at +0 (bit `s` is source `s`), threshold at +4, and claim/complete at +8.
  - Target `c` is thread c/2 in machine mode when c is even and in supervisor mode when c is odd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| src_i | input | NUM_SRC | Level interrupt inputs; bit s-1 is source s |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Register request ready |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response ready |
| rsp_rdata_o | output | 32 | Read data (0 for writes) |
| irq_o | output | 2*NUM_HART | Interrupt line per target |

## Verification
The bench builds the block with seven sources, two hardware threads (four targets) and three-bit priorities. The narrow priority field makes truncation of wide writes observable, and seven sources leave room for equal-priority ties and for a source that sits exactly at a threshold. Two threads let suppression on one thread be checked against a post that still reaches the other thread, and let one source be fought over by targets on different threads.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  // fixed byte offsets of the register windows
  localparam int unsigned PEND_OFS = 'h080;
  localparam int unsigned CTX_OFS  = 'h100;

  // word selector inside one target's 16-byte window
  typedef enum logic [1:0] {
    CREG_ENABLE = 2'd0,
    CREG_THRESH = 2'd1,
    CREG_CLAIM  = 2'd2,
    CREG_NONE   = 2'd3
  } ctx_reg_e;
endpackage

// File: rtl/extirq_gateway.sv
// Per-source request capture: input register, pending and in-service state.
module extirq_gateway (
  input  logic clk_i,
  input  logic rst_i,
  input  logic level_i,
  input  logic take_i,
  input  logic done_i,
  output logic pend_o,
  output logic insvc_o
);
  logic sync_q, pend_q, insvc_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sync_q  <= 1'b0;
      pend_q  <= 1'b0;
      insvc_q <= 1'b0;
    end else begin
      sync_q <= level_i;
      if (take_i) begin
        pend_q  <= 1'b0;
        insvc_q <= 1'b1;
      end else begin
        if (sync_q && !insvc_q && !pend_q) pend_q <= 1'b1;
        if (done_i) insvc_q <= 1'b0;
      end
    end
  end

  assign pend_o  = pend_q;
  assign insvc_o = insvc_q;
endmodule

// File: rtl/extirq_select.sv
// Picks the best eligible source for one target; lower id wins ties.
module extirq_select #(
  parameter int NUM_SRC = 7,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 3
) (
  input  logic [NUM_SRC:1][PRIO_W-1:0] prio_i,
  input  logic [NUM_SRC:1]             pend_i,
  input  logic [NUM_SRC:1]             en_i,
  input  logic [PRIO_W-1:0]            thr_i,
  output logic [ID_W-1:0]              best_o
);
  logic [PRIO_W-1:0] top;

  always_comb begin
    best_o = '0;
    top    = '0;
    // descending scan with >= leaves the lowest id among equals
    for (int s = NUM_SRC; s >= 1; s--) begin
      if (pend_i[s] && en_i[s] && (prio_i[s] > thr_i) &&
          ((best_o == '0) || (prio_i[s] >= top))) begin
        best_o = ID_W'(s);
        top    = prio_i[s];
      end
    end
  end
endmodule

// File: rtl/extirq_target.sv
// One interrupt target: enable bits, threshold, claim ownership, line.
module extirq_target
  import extirq_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 3
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               sel_i,
  input  logic               wr_i,
  input  ctx_reg_e           reg_i,
  input  logic [31:0]        wdata_i,
  input  logic [ID_W-1:0]    best_i,
  input  logic               hold_i,
  output logic [NUM_SRC:1]   en_o,
  output logic [PRIO_W-1:0]  thr_o,
  output logic [ID_W-1:0]    offer_o,
  output logic               take_o,
  output logic [ID_W-1:0]    owned_o,
  output logic               done_o,
  output logic               irq_o
);
  logic [NUM_SRC:1]  en_q;
  logic [PRIO_W-1:0] thr_q;
  logic [ID_W-1:0]   own_q;
  logic              irq_q;

  assign offer_o = (own_q == '0) ? best_i : '0;
  assign take_o  = sel_i && !wr_i && (reg_i == CREG_CLAIM) && (offer_o != '0);
  assign done_o  = sel_i && wr_i && (reg_i == CREG_CLAIM) && (own_q != '0) &&
                   (wdata_i == 32'(own_q));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      en_q  <= '0;
      thr_q <= '0;
      own_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (sel_i && wr_i && (reg_i == CREG_ENABLE)) en_q  <= wdata_i[NUM_SRC:1];
      if (sel_i && wr_i && (reg_i == CREG_THRESH)) thr_q <= wdata_i[PRIO_W-1:0];
      if (take_o)      own_q <= best_i;
      else if (done_o) own_q <= '0;
      irq_q <= (best_i != '0) && !hold_i;
    end
  end

  assign en_o    = en_q;
  assign thr_o   = thr_q;
  assign owned_o = own_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/extirq_router.sv
module extirq_router
  import extirq_pkg::*;
#(
  parameter int NUM_SRC  = 7,
  parameter int NUM_HART = 2,
  parameter int PRIO_W   = 3,
  parameter int ADDR_W   = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic [NUM_SRC-1:0]    src_i,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic                  req_write_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [31:0]           req_wdata_i,
  output logic                  rsp_valid_o,
  input  logic                  rsp_ready_i,
  output logic [31:0]           rsp_rdata_o,
  output logic [2*NUM_HART-1:0] irq_o
);
  localparam int NUM_CTX = 2 * NUM_HART;
  localparam int ID_W    = $clog2(NUM_SRC + 1);
  localparam int CIDX_W  = ADDR_W - 4;

  // ---------------- bus handshake ----------------
  logic        rsp_valid_q;
  logic [31:0] rsp_data_q;
  logic        accept;
  logic [31:0] rdata;

  assign req_ready_o = !rsp_valid_q || rsp_ready_i;
  assign accept      = req_valid_i && req_ready_o;

  // ---------------- address decode ----------------
  logic [4:0]        src_sel;
  logic              prio_hit, pend_hit, ctx_hit;
  logic [ADDR_W-1:0] ctx_rel;
  logic [CIDX_W-1:0] ctx_num;
  ctx_reg_e          ctx_reg;

  assign src_sel  = req_addr_i[6:2];
  assign prio_hit = (req_addr_i[ADDR_W-1:7] == '0) && (req_addr_i[1:0] == 2'b00) &&
                    (src_sel != 5'd0) && (src_sel <= 5'(NUM_SRC));
  assign pend_hit = (req_addr_i == ADDR_W'(PEND_OFS));
  assign ctx_rel  = req_addr_i - ADDR_W'(CTX_OFS);
  assign ctx_num  = ctx_rel[ADDR_W-1:4];
  assign ctx_reg  = ctx_reg_e'(ctx_rel[3:2]);
  assign ctx_hit  = (req_addr_i >= ADDR_W'(CTX_OFS)) && (ctx_num < CIDX_W'(NUM_CTX)) &&
                    (ctx_rel[1:0] == 2'b00) && (ctx_reg != CREG_NONE);

  // ---------------- source priorities ----------------
  logic [NUM_SRC:1][PRIO_W-1:0] prio_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prio_q <= '0;
    end else begin
      for (int s = 1; s <= NUM_SRC; s++) begin
        if (accept && req_write_i && prio_hit && (src_sel == 5'(s)))
          prio_q[s] <= req_wdata_i[PRIO_W-1:0];
      end
    end
  end

  // ---------------- per-source gateways ----------------
  logic [NUM_SRC:1] pend, insvc, take_src, done_src;

  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_src
    extirq_gateway u_gw (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .level_i (src_i[s-1]),
      .take_i  (take_src[s]),
      .done_i  (done_src[s]),
      .pend_o  (pend[s]),
      .insvc_o (insvc[s])
    );
  end

  // ---------------- per-target state ----------------
  logic [NUM_CTX-1:0][NUM_SRC:1]  en;
  logic [NUM_CTX-1:0][PRIO_W-1:0] thr;
  logic [NUM_CTX-1:0][ID_W-1:0]   best, offer, claim_id;
  logic [NUM_CTX-1:0]             take, done;
  logic [NUM_HART-1:0]            hart_busy;

  for (genvar h = 0; h < NUM_HART; h++) begin : g_hart
    assign hart_busy[h] = (claim_id[2*h] != '0) || (claim_id[2*h+1] != '0);
  end

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    logic sel;
    assign sel = accept && ctx_hit && (ctx_num == CIDX_W'(c));

    extirq_select #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_sel (
      .prio_i (prio_q),
      .pend_i (pend),
      .en_i   (en[c]),
      .thr_i  (thr[c]),
      .best_o (best[c])
    );

    extirq_target #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_tgt (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .sel_i   (sel),
      .wr_i    (req_write_i),
      .reg_i   (ctx_reg),
      .wdata_i (req_wdata_i),
      .best_i  (best[c]),
      .hold_i  (hart_busy[c/2]),
      .en_o    (en[c]),
      .thr_o   (thr[c]),
      .offer_o (offer[c]),
      .take_o  (take[c]),
      .owned_o (claim_id[c]),
      .done_o  (done[c]),
      .irq_o   (irq_o[c])
    );
  end

  // route claim/complete events back to the owning source
  always_comb begin
    take_src = '0;
    done_src = '0;
    for (int s = 1; s <= NUM_SRC; s++) begin
      for (int c = 0; c < NUM_CTX; c++) begin
        if (take[c] && (offer[c] == ID_W'(s)))    take_src[s] = 1'b1;
        if (done[c] && (claim_id[c] == ID_W'(s))) done_src[s] = 1'b1;
      end
    end
  end

  // ---------------- read data ----------------
  always_comb begin
    rdata = '0;
    if (prio_hit) begin
      for (int s = 1; s <= NUM_SRC; s++)
        if (src_sel == 5'(s)) rdata = 32'(prio_q[s]);
    end else if (pend_hit) begin
      rdata = 32'({pend, 1'b0});
    end else if (ctx_hit) begin
      for (int c = 0; c < NUM_CTX; c++) begin
        if (ctx_num == CIDX_W'(c)) begin
          case (ctx_reg)
            CREG_ENABLE: rdata = 32'({en[c], 1'b0});
            CREG_THRESH: rdata = 32'(thr[c]);
            CREG_CLAIM:  rdata = 32'(offer[c]);
            default:     rdata = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= req_write_i ? '0 : rdata;
    end else if (rsp_ready_i) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_data_q;
endmodule

// File: rtl/extirq_router_chk.sv
module extirq_router_chk #(
  parameter int NUM_SRC  = 7,
  parameter int NUM_HART = 2,
  parameter int ID_W     = 3
) (
  input logic                                clk_i,
  input logic                                rst_i,
  input logic [2*NUM_HART-1:0]               irq_i,
  input logic [2*NUM_HART-1:0][ID_W-1:0]     claim_i,
  input logic [NUM_SRC:1]                    pend_i,
  input logic [NUM_SRC:1]                    insvc_i,
  input logic                                rsp_valid_i,
  input logic                                rsp_ready_i,
  input logic [31:0]                         rsp_rdata_i
);
  localparam int NUM_CTX = 2 * NUM_HART;

  logic [NUM_HART-1:0] busy;
  for (genvar h = 0; h < NUM_HART; h++) begin : g_busy
    assign busy[h] = (claim_i[2*h] != '0) || (claim_i[2*h+1] != '0);
  end

  // R11: a stalled response keeps its data
  assert_rsp_hold_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    (rsp_valid_i && !rsp_ready_i) |=> (rsp_valid_i && $stable(rsp_rdata_i)));

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx_chk
    // R7: an outstanding claim may only be released, never replaced
    assert_lockstep_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (($past(claim_i[c]) != '0) && (claim_i[c] != $past(claim_i[c]))) |-> (claim_i[c] == '0));
    // R10: a thread busy for two cycles has both lines low
    assert_suppress_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      (busy[c/2] && $past(busy[c/2])) |-> !irq_i[c]);
  end

  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_src_chk
    logic [NUM_CTX-1:0] owner;
    always_comb begin
      for (int c = 0; c < NUM_CTX; c++) owner[c] = (claim_i[c] == ID_W'(s));
    end
    // R6: at most one target owns a source
    assert_single_owner_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      $countones(owner) <= 1);
    // R9: an in-service source is never pending
    assert_no_repend_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      insvc_i[s] |-> !pend_i[s]);
  end
endmodule

bind extirq_router extirq_router_chk #(
  .NUM_SRC(NUM_SRC), .NUM_HART(NUM_HART), .ID_W(ID_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .irq_i       (irq_o),
  .claim_i     (claim_id),
  .pend_i      (pend),
  .insvc_i     (insvc),
  .rsp_valid_i (rsp_valid_o),
  .rsp_ready_i (rsp_ready_i),
  .rsp_rdata_i (rsp_rdata_o)
);

// File: tb/extirq_router_test.sv
`timescale 1ns/1ps
module extirq_router_test;
  localparam int NS = 7;
  localparam int NH = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [NS-1:0] src = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [2*NH-1:0] irq;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  extirq_router #(.NUM_SRC(NS), .NUM_HART(NH), .PRIO_W(3), .ADDR_W(12)) uut (
    .clk_i(clk), .rst_i(rst), .src_i(src),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_rdata_o(rsp_rdata),
    .irq_o(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
  } op_t;

  localparam int NOPS = 16;
  localparam op_t OPS [NOPS] = '{
    '{1'b1, 12'h004, 32'd1,          32'd0},   // prio src1 = 1
    '{1'b1, 12'h008, 32'hFFFF_FFFD,  32'd0},   // prio src2 = 5 after truncation
    '{1'b1, 12'h00C, 32'd5,          32'd0},   // prio src3 = 5
    '{1'b1, 12'h010, 32'd2,          32'd0},
    '{1'b1, 12'h014, 32'd7,          32'd0},
    '{1'b1, 12'h000, 32'd7,          32'd0},   // id 0 slot: ignored
    '{1'b0, 12'h000, 32'd0,          32'd0},   // R2
    '{1'b0, 12'h008, 32'd0,          32'd5},   // R2 truncation
    '{1'b0, 12'h014, 32'd0,          32'd7},   // R2
    '{1'b0, 12'h01C, 32'd0,          32'd0},   // R2 never written
    '{1'b1, 12'h100, 32'h0000_000F,  32'd0},   // target 0 enables src1..3
    '{1'b0, 12'h100, 32'd0,          32'h0E},  // R12 bit 0 not stored
    '{1'b1, 12'h104, 32'd1,          32'd0},   // target 0 threshold 1
    '{1'b0, 12'h104, 32'd0,          32'd1},   // R12
    '{1'b0, 12'h080, 32'd0,          32'd0},   // R12 nothing pending
    '{1'b0, 12'h108, 32'd0,          32'd0}    // R5 empty claim gives 0
  };

  function automatic string row_tag(int i);
    case (i)
      6, 7, 8, 9: return "R2";
      15:         return "R5";
      default:    return "R12";
    endcase
  endfunction

  task automatic expect32(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus transaction; starts and ends at a falling edge
  task automatic bus(input logic wr, input logic [11:0] a, input logic [31:0] d,
                     output logic [31:0] q);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    q = rsp_rdata;
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    expect32("R1 irq", 32'(irq), 32'd0);
    expect32("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    expect32("R1 req_ready", 32'(req_ready), 32'd1);

    for (int i = 0; i < NOPS; i++) begin
      bus(OPS[i].wr, OPS[i].addr, OPS[i].data, q);
      if (!OPS[i].wr) expect32(row_tag(i), q, OPS[i].exp);
    end

    // R3: three-edge latency from source 2 to target 0
    src[1] = 1'b1;
    wait_cycles(2);
    expect32("R3 line before third edge", 32'(irq[0]), 32'd0);
    wait_cycles(1);
    expect32("R3 line after third edge", 32'(irq[0]), 32'd1);
    expect32("R3 unenabled target", 32'(irq[1]), 32'd0);
    bus(1'b0, 12'h080, 0, q);
    expect32("R12 pending src2", q, 32'h04);

    // R5: tie at priority 5 between src2 and src3; src1 at threshold
    src[2] = 1'b1; src[0] = 1'b1;
    wait_cycles(3);
    bus(1'b0, 12'h080, 0, q);
    expect32("R12 pending 1..3", q, 32'h0E);
    bus(1'b0, 12'h108, 0, q);
    expect32("R5 tie lower id", q, 32'd2);
    bus(1'b0, 12'h080, 0, q);
    expect32("R5 pending cleared", q, 32'h0A);

    // R10: thread 0 busy, thread 1 still served
    bus(1'b1, 12'h110, 32'h08, q);
    bus(1'b1, 12'h114, 32'd0, q);
    bus(1'b1, 12'h120, 32'h08, q);
    bus(1'b1, 12'h124, 32'd0, q);
    wait_cycles(2);
    expect32("R10 lines", 32'(irq), 32'b0100);

    // R7: second claim while one is outstanding
    bus(1'b0, 12'h108, 0, q);
    expect32("R7 claim while held", q, 32'd0);
    bus(1'b0, 12'h080, 0, q);
    expect32("R9 src2 stays clear while held", q, 32'h0A);

    // R8: wrong-id completion
    bus(1'b1, 12'h108, 32'd3, q);
    wait_cycles(2);
    expect32("R8 thread still busy", 32'(irq[1]), 32'd0);

    // R6: src3 claimed by target 2, not visible to target 1
    bus(1'b0, 12'h128, 0, q);
    expect32("R5 claim target2", q, 32'd3);
    bus(1'b0, 12'h118, 0, q);
    expect32("R6 exclusive claim", q, 32'd0);

    // R9: completion re-arms a still-high source
    bus(1'b1, 12'h108, 32'd2, q);
    wait_cycles(2);
    expect32("R3 R10 lines after complete", 32'(irq), 32'b0001);
    bus(1'b0, 12'h080, 0, q);
    expect32("R9 re-pending", q, 32'h06);

    // R4: threshold equal to the priority blocks the line
    bus(1'b1, 12'h104, 32'd5, q);
    wait_cycles(2);
    expect32("R4 threshold equal", 32'(irq[0]), 32'd0);
    bus(1'b1, 12'h104, 32'd4, q);
    wait_cycles(2);
    expect32("R4 threshold below", 32'(irq[0]), 32'd1);

    // R11: response back-pressure
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h014;
    @(posedge clk);
    @(negedge clk);
    req_addr = 12'h004;
    expect32("R11 rsp valid", 32'(rsp_valid), 32'd1);
    expect32("R11 ready low", 32'(req_ready), 32'd0);
    expect32("R11 data", rsp_rdata, 32'd7);
    wait_cycles(1);
    expect32("R11 data held", rsp_rdata, 32'd7);
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    expect32("R11 next response", rsp_rdata, 32'd1);
    wait_cycles(1);
    expect32("R11 drained", 32'(rsp_valid), 32'd0);

    finished = 1;
    summary();
    $finish;
  end
endmodule